// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block watches a byte stream of 16-bit legacy-style machine code and finds where each instruction begins and ends. It takes one byte per cycle when the input is valid. For each instruction it reports the start of the instruction and, on the last byte, the total length from 1 to 6 bytes. It also reports where the register/memory specifier byte, the displacement and the immediate sit within that instruction.

The length depends on the opcode and on the addressing byte that follows it. For opcodes that take an addressing byte, the length is therefore settled only on the second byte. The decoder handles a small opcode set: no-op, the one-byte register increments, the four ADD register/memory forms, the three ADD-with-immediate groups and the near relative jump. Any other opcode byte raises a one-cycle error pulse, and the next byte is taken as a fresh opcode.

Top module: `insn_len_decoder`

## Requirements
- R1: `in_ready` is always 1. A byte is taken on a rising edge only while `in_valid` is 1. A cycle without `in_valid` produces no `sop`, `done` or `err` pulse and does not move the decoder forward.
- R2: For a supported opcode byte, `sop` is 1 for exactly the one cycle that follows the edge on which that byte was taken. Addressing, displacement and immediate bytes never raise `sop`.
- R3: Opcode 0x90 and opcodes 0x40 to 0x47 are complete 1-byte instructions. `done` and `sop` are raised together, with `len` = 1 and all field positions and sizes 0.
- R4: Opcode 0xE9 is 3 bytes long. It has no addressing byte (`modrm_pos` = 0), a 2-byte displacement at position 1 (`disp_pos` = 1, `disp_len` = 2) and no immediate.
- R5: Opcodes 0x00 to 0x03 take an addressing byte at position 1 (`modrm_pos` = 1) and carry no immediate (`imm_len` = 0, `imm_pos` = 0).
- R6: The displacement size comes from the addressing byte, where mod is bits 7:6 and r/m is bits 2:0. mod=11 gives 0 bytes, mod=01 gives 1 byte and mod=10 gives 2 bytes. mod=00 gives 0 bytes, except r/m=110, which gives 2. A nonzero displacement sits at position 2; otherwise `disp_pos` = 0.
- R7: Opcodes 0x80 and 0x83 carry a 1-byte immediate and opcode 0x81 carries a 2-byte immediate. The immediate follows the displacement (`imm_pos` = 2 + displacement size).
- R8: Any other opcode byte produces a one-cycle `err` pulse with no `sop` and no `done`. The next byte taken is decoded as an opcode.
- R9: `done` pulses exactly once per supported instruction, in the cycle after its last byte is taken. At that point `len` equals 1 + `modrm_pos` + `disp_len` + `imm_len` and lies in 1 to 6. Position and size ports are meaningful only while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Byte accepted whenever offered (constant 1) |
| sop | output | 1 | Start of a supported instruction |
| done | output | 1 | Last byte of an instruction taken; fields valid |
| err | output | 1 | Unsupported opcode seen |
| len | output | 3 | Instruction length in bytes |
| modrm_pos | output | 3 | Position of the addressing byte, 0 if none |
| disp_pos | output | 3 | Position of the displacement, 0 if none |
| disp_len | output | 2 | Displacement size in bytes |
| imm_pos | output | 3 | Position of the immediate, 0 if none |
| imm_len | output | 2 | Immediate size in bytes |

## Verification
Every result is registered once. `sop`, `err` and the 1-byte `done` appear in the cycle after the opcode's edge. A multi-byte `done` and its fields appear in the cycle after the edge of that instruction's final byte. The bench drives each byte on the falling edge and reads the outputs 1 ns after the rising edge that takes it, so every byte is paired with its own result. Intermediate bytes are checked to show no `done` and no `sop`. Idle cycles inserted between instructions are checked to show no pulse at all.

// File: rtl/ild_pkg.sv
package ild_pkg;

   // Summary of what an opcode byte implies about the bytes after it
   typedef struct packed {
      logic       ok;      // opcode is in the supported set
      logic       modrm;   // an addressing byte follows
      logic [1:0] imm;     // immediate bytes after any displacement
      logic [1:0] fixed;   // displacement bytes implied by opcode alone
   } op_class_t;

   typedef enum logic [1:0] {
      ST_OP    = 2'd0,
      ST_MODRM = 2'd1,
      ST_TAIL  = 2'd2
   } ild_state_e;

endpackage

// File: rtl/ild_opclass.sv
module ild_opclass
   import ild_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter bit SUPPORT_INC = 1'b1
) (
   input  logic [BYTE_W-1:0] op,
   output op_class_t         cls
);

   logic inc_hit;

   generate
      if (SUPPORT_INC) begin : g_inc
         assign inc_hit = (op[7:3] == 5'b01000);
      end else begin : g_no_inc
         assign inc_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      cls = '0;
      unique case (op)
         8'h90: cls.ok = 1'b1;
         8'h00, 8'h01, 8'h02, 8'h03: begin
            cls.ok    = 1'b1;
            cls.modrm = 1'b1;
         end
         8'h80, 8'h83: begin
            cls.ok    = 1'b1;
            cls.modrm = 1'b1;
            cls.imm   = 2'd1;
         end
         8'h81: begin
            cls.ok    = 1'b1;
            cls.modrm = 1'b1;
            cls.imm   = 2'd2;
         end
         8'hE9: begin
            cls.ok    = 1'b1;
            cls.fixed = 2'd2;
         end
         default: cls.ok = inc_hit;
      endcase
   end

endmodule

// File: rtl/ild_dispsize.sv
module ild_dispsize #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] modrm,
   output logic [1:0]        disp_sz
);

   logic [1:0] mode;
   logic [2:0] rm;

   assign mode = modrm[7:6];
   assign rm   = modrm[2:0];

   always_comb begin
      unique case (mode)
         2'b00:   disp_sz = (rm == 3'b110) ? 2'd2 : 2'd0;
         2'b01:   disp_sz = 2'd1;
         2'b10:   disp_sz = 2'd2;
         default: disp_sz = 2'd0;
      endcase
   end

endmodule

// File: rtl/ild_track.sv
module ild_track
   import ild_pkg::*;
#(
   parameter int LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  op_class_t        cls,
   input  logic [1:0]       disp_sz,
   output logic             sop_o,
   output logic             done_o,
   output logic             err_o,
   output logic [LEN_W-1:0] len_o,
   output logic [LEN_W-1:0] modrm_pos_o,
   output logic [LEN_W-1:0] disp_pos_o,
   output logic [1:0]       disp_len_o,
   output logic [LEN_W-1:0] imm_pos_o,
   output logic [1:0]       imm_len_o
);

   ild_state_e       st;
   logic [LEN_W-1:0] cnt;
   logic [1:0]       imm_q;
   logic [LEN_W-1:0] tail;

   assign tail = LEN_W'(disp_sz) + LEN_W'(imm_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_OP;
         cnt         <= '0;
         imm_q       <= '0;
         sop_o       <= 1'b0;
         done_o      <= 1'b0;
         err_o       <= 1'b0;
         len_o       <= '0;
         modrm_pos_o <= '0;
         disp_pos_o  <= '0;
         disp_len_o  <= '0;
         imm_pos_o   <= '0;
         imm_len_o   <= '0;
      end else begin
         sop_o  <= 1'b0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
         if (in_valid) begin
            unique case (st)
               ST_OP: begin
                  if (!cls.ok) begin
                     err_o <= 1'b1;
                  end else begin
                     sop_o       <= 1'b1;
                     imm_q       <= cls.imm;
                     modrm_pos_o <= '0;
                     imm_pos_o   <= '0;
                     imm_len_o   <= '0;
                     if (cls.modrm) begin
                        st <= ST_MODRM;
                     end else if (cls.fixed == 2'd0) begin
                        done_o     <= 1'b1;
                        len_o      <= LEN_W'(1);
                        disp_pos_o <= '0;
                        disp_len_o <= '0;
                     end else begin
                        len_o      <= LEN_W'(1) + LEN_W'(cls.fixed);
                        disp_pos_o <= LEN_W'(1);
                        disp_len_o <= cls.fixed;
                        cnt        <= LEN_W'(cls.fixed);
                        st         <= ST_TAIL;
                     end
                  end
               end
               ST_MODRM: begin
                  len_o       <= LEN_W'(2) + tail;
                  modrm_pos_o <= LEN_W'(1);
                  disp_len_o  <= disp_sz;
                  disp_pos_o  <= (disp_sz != 2'd0) ? LEN_W'(2) : '0;
                  imm_len_o   <= imm_q;
                  imm_pos_o   <= (imm_q != 2'd0) ? LEN_W'(2) + LEN_W'(disp_sz) : '0;
                  if (tail == '0) begin
                     done_o <= 1'b1;
                     st     <= ST_OP;
                  end else begin
                     cnt <= tail;
                     st  <= ST_TAIL;
                  end
               end
               ST_TAIL: begin
                  cnt <= cnt - LEN_W'(1);
                  if (cnt == LEN_W'(1)) begin
                     done_o <= 1'b1;
                     st     <= ST_OP;
                  end
               end
               default: st <= ST_OP;
            endcase
         end
      end
   end

endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
   import ild_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int MAX_LEN     = 6,
   parameter bit SUPPORT_INC = 1'b1,
   localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   output logic              in_ready,
   output logic              sop,
   output logic              done,
   output logic              err,
   output logic [LEN_W-1:0]  len,
   output logic [LEN_W-1:0]  modrm_pos,
   output logic [LEN_W-1:0]  disp_pos,
   output logic [1:0]        disp_len,
   output logic [LEN_W-1:0]  imm_pos,
   output logic [1:0]        imm_len
);

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("insn_len_decoder: BYTE_W must be 8");
      end
      if (MAX_LEN < 6) begin : g_bad_len
         $error("insn_len_decoder: MAX_LEN must cover 6-byte instructions");
      end
   endgenerate

   op_class_t  cls;
   logic [1:0] disp_sz;

   assign in_ready = 1'b1;

   ild_opclass #(.BYTE_W(BYTE_W), .SUPPORT_INC(SUPPORT_INC)) u_opclass (
      .op  (in_data),
      .cls (cls)
   );

   ild_dispsize #(.BYTE_W(BYTE_W)) u_dispsize (
      .modrm   (in_data),
      .disp_sz (disp_sz)
   );

   ild_track #(.LEN_W(LEN_W)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .cls         (cls),
      .disp_sz     (disp_sz),
      .sop_o       (sop),
      .done_o      (done),
      .err_o       (err),
      .len_o       (len),
      .modrm_pos_o (modrm_pos),
      .disp_pos_o  (disp_pos),
      .disp_len_o  (disp_len),
      .imm_pos_o   (imm_pos),
      .imm_len_o   (imm_len)
   );

endmodule

// File: rtl/ild_checker.sv
module ild_checker #(
   parameter int LEN_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             sop,
   input logic             done,
   input logic             err,
   input logic [LEN_W-1:0] len,
   input logic [LEN_W-1:0] modrm_pos,
   input logic [1:0]       disp_len,
   input logic [1:0]       imm_len
);

   a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == 1'b1);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!sop && !done && !err));

   a_r8_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!sop && !done));

   a_r9_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (len >= LEN_W'(1) && len <= LEN_W'(6)));

   a_r9_len_sum: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (len == LEN_W'(1) + modrm_pos + LEN_W'(disp_len) + LEN_W'(imm_len)));

   a_r3_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (done && len == LEN_W'(1)) |-> sop);

endmodule

bind insn_len_decoder ild_checker #(.LEN_W(LEN_W)) u_ild_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .sop       (sop),
   .done      (done),
   .err       (err),
   .len       (len),
   .modrm_pos (modrm_pos),
   .disp_len  (disp_len),
   .imm_len   (imm_len)
);

// File: tb/test_insn_len_decoder.sv
module test_insn_len_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready, sop, done, err;
   logic [2:0] len, modrm_pos, disp_pos, imm_pos;
   logic [1:0] disp_len, imm_len;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   insn_len_decoder i_insn_len_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .sop(sop), .done(done), .err(err), .len(len),
      .modrm_pos(modrm_pos), .disp_pos(disp_pos), .disp_len(disp_len),
      .imm_pos(imm_pos), .imm_len(imm_len)
   );

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      chk(in_ready, 1, "R1 ready");
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'h90;
      @(posedge clk);
      #1;
      chk({sop, done, err}, 0, "R1 idle quiet");
   endtask

   function automatic int disp_of(input logic [7:0] m);
      case (m[7:6])
         2'b00:   return (m[2:0] == 3'b110) ? 2 : 0;
         2'b01:   return 1;
         2'b10:   return 2;
         default: return 0;
      endcase
   endfunction

   // Feed one instruction; filler bytes 0x90 must be treated as data
   task automatic run_instr(input logic [7:0] op, input logic [7:0] m);
      bit ok, has_m;
      int imm, d, total, exp_mp, exp_dp, exp_ip;
      ok = 1'b1; has_m = 1'b0; imm = 0; d = 0;
      if (op == 8'h90 || op[7:3] == 5'b01000) d = 0;
      else if (op <= 8'h03) has_m = 1'b1;
      else if (op == 8'h80 || op == 8'h83) begin has_m = 1'b1; imm = 1; end
      else if (op == 8'h81) begin has_m = 1'b1; imm = 2; end
      else if (op == 8'hE9) d = 2;
      else ok = 1'b0;

      send(op);
      if (!ok) begin
         chk(err, 1, "R8 err on unsupported");
         chk({sop, done}, 0, "R8 no sop/done on unsupported");
         return;
      end
      chk(sop, 1, "R2 sop on opcode");
      chk(err, 0, "R8 no err on supported");
      if (has_m) d = disp_of(m);
      total = 1 + (has_m ? 1 : 0) + d + imm;
      exp_mp = has_m ? 1 : 0;
      exp_dp = (d == 0) ? 0 : (has_m ? 2 : 1);
      exp_ip = (imm == 0) ? 0 : 2 + d;
      if (total == 1) begin
         chk(done, 1, "R3 done on 1-byte");
         chk(len, 1, "R3 len 1");
         chk({modrm_pos, disp_pos, disp_len, imm_pos, imm_len}, 0, "R3 fields zero");
         return;
      end
      chk(done, 0, "R9 no early done");
      for (int k = 1; k < total; k++) begin
         send((k == 1 && has_m) ? m : 8'h90);
         chk(sop, 0, "R2 no sop on body byte");
         if (k < total - 1) begin
            chk(done, 0, "R9 no early done");
         end else begin
            chk(done, 1, "R9 done on last byte");
            chk(len, total, (op == 8'hE9) ? "R4 jump len" : "R9 len");
            chk(modrm_pos, exp_mp, has_m ? "R5 modrm pos" : "R4 no modrm");
            chk(disp_len, d, "R6 disp len");
            chk(disp_pos, exp_dp, "R6 disp pos");
            chk(imm_len, imm, "R7 imm len");
            chk(imm_pos, exp_ip, (op <= 8'h03) ? "R5 no imm" : "R7 imm pos");
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk({sop, done, err}, 0, "R1 pulses low in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk({sop, done, err, len}, 0, "R9 reset state");
      // every opcode, with varied addressing bytes and idle gaps
      for (int op = 0; op < 256; op++) begin
         run_instr(8'(op), 8'(op * 37 + 11));
         if (op[0]) idle();
      end
      // every addressing byte for each immediate size and none
      for (int m = 0; m < 256; m++) begin
         run_instr(8'h02, 8'(m));
         run_instr(8'h83, 8'(m));
         run_instr(8'h81, 8'(m));
      end
      // resync: unsupported followed directly by a jump
      run_instr(8'hFF, 8'h00);
      run_instr(8'hE9, 8'h00);
      // paper cases: 2-byte register form and 4-byte direct form
      run_instr(8'h01, 8'hC3);
      run_instr(8'h03, 8'h1E);
      idle();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule